// File: doc/BRIEF.md
# Sliding-Window Filter Sequencer

This block sequences a 3x3 (parameterisable) neighbourhood filter over an image that already sits in an on-chip memory. For each window position it issues one read per tap, stepping through the taps row by row. Each read presents two addresses that move in lockstep: one into the image store and one into the coefficient store. A strobe marks the cycles whose addresses are meaningful. The multiply-accumulate unit and the memories sit outside this block. The sequencer only addresses them, pads for their latency, waits for the accumulator to report a finished sum, and then writes that sum into the result store at the next sequential address.

The window origin visits only the positions where the whole kernel lies inside the image. It walks along a row one pixel at a time and then moves down one row. A `start` pulse launches a pass from the idle state or from the finished state. A `done` flag stays high after the last result is written until the next pass is launched.

Top module: `conv_window_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rd_valid`, `res_we` and `done` are 0 and `res_addr` is 0.
- R2: A `start` sampled high at a clock edge while idle or finished makes `rd_valid` high in the next cycle, with `img_addr` = 0 and `coef_addr` = 0.
- R3: Each window gives exactly KSIZE*KSIZE consecutive strobe cycles. The taps go in row-major order (dx fastest), with `coef_addr` = dy*KSIZE+dx and `img_addr` = (i+dy)*IMG_W + (j+dx), where (i, j) is the window origin.
- R4: After the last tap of a window, `rd_valid` and `res_we` stay low for three cycles: two alignment cycles and one stop cycle. Only then does the block start waiting for `mac_done`.
- R5: While waiting with `mac_done` low, the block holds: no strobe, no write, and `res_addr` unchanged.
- R6: When `mac_done` is high in the waiting state, `res_we` is high for that single cycle, with `res_addr` equal to the number of results already written in this pass. `res_addr` then increments, and the next window's first tap is presented in the following cycle.
- R7: The origin steps j from 0 to IMG_W-KSIZE and then advances i, until i = IMG_H-KSIZE. A pass writes exactly (IMG_H-KSIZE+1)*(IMG_W-KSIZE+1) results.
- R8: In the cycle after the last write, `done` goes high. It stays high until a `start` is sampled. That `start` relaunches from origin (0,0) with `res_addr` back at 0.
- R9: `mac_done` outside the waiting state has no effect on any output.
- R10: `start` while a pass is in progress has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a pass (honoured only when idle or finished) |
| mac_done | input | 1 | Accumulator reports the current window sum is ready |
| rd_valid | output | 1 | Read strobe to both memories |
| img_addr | output | clog2(IMG_H*IMG_W) | Image memory read address |
| coef_addr | output | clog2(KSIZE*KSIZE) | Coefficient memory read address |
| res_we | output | 1 | Result memory write enable |
| res_addr | output | clog2(N_OUT+1) | Result memory write address / results written so far |
| done | output | 1 | Pass complete |

## Verification
A tap counter that slips by one shows up as a wrong `coef_addr` within the same strobe burst, and it shortens or lengthens that burst. A wrong window origin shows up as a wrong `img_addr` on the very first strobe of the next window. A skipped alignment or stop state makes the next burst or the write arrive a cycle early, so it shows up at the latest within four cycles of the burst ending. A result counter that is not cleared or is double-stepped is visible on `res_addr` at once, and it shows again in `done` rising after the wrong number of writes.

// File: rtl/conv_win_pkg.sv
package conv_win_pkg;

    typedef enum logic [2:0] {
        ST_INIT    = 3'd0,
        ST_ISSUE   = 3'd1,
        ST_ALIGN_A = 3'd2,
        ST_ALIGN_B = 3'd3,
        ST_HALT    = 3'd4,
        ST_WAIT    = 3'd5,
        ST_FINISH  = 3'd6
    } ctrl_state_e;

    typedef struct packed {
        logic clear;
        logic step;
    } cnt_cmd_t;

    function automatic int clog2_min1(input int v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

    function automatic bit is_pow2(input int v);
        return (v > 1) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/conv_grid_counter.sv
module conv_grid_counter
    import conv_win_pkg::*;
#(
    parameter int COLS = 3,
    parameter int ROWS = 3,
    localparam int CW = clog2_min1(COLS),
    localparam int RW = clog2_min1(ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  cnt_cmd_t      cmd,
    output logic [CW-1:0] col,
    output logic [RW-1:0] row,
    output logic          last
);

    logic col_end;
    logic row_end;

    assign col_end = (col == CW'(COLS - 1));
    assign row_end = (row == RW'(ROWS - 1));
    assign last    = col_end && row_end;

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            col <= '0;
            row <= '0;
        end else if (cmd.step) begin
            if (col_end) begin
                col <= '0;
                row <= row_end ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

endmodule

// File: rtl/conv_addr_gen.sv
module conv_addr_gen
    import conv_win_pkg::*;
#(
    parameter int IMG_H = 8,
    parameter int IMG_W = 8,
    parameter int KSIZE = 3,
    localparam int OUT_ROWS = IMG_H - KSIZE + 1,
    localparam int OUT_COLS = IMG_W - KSIZE + 1,
    localparam int WRW = clog2_min1(OUT_ROWS),
    localparam int WCW = clog2_min1(OUT_COLS),
    localparam int TW  = clog2_min1(KSIZE),
    localparam int IA_W = clog2_min1(IMG_H * IMG_W),
    localparam int CA_W = clog2_min1(KSIZE * KSIZE)
) (
    input  logic [WRW-1:0]  win_row,
    input  logic [WCW-1:0]  win_col,
    input  logic [TW-1:0]   tap_row,
    input  logic [TW-1:0]   tap_col,
    output logic [IA_W-1:0] img_addr,
    output logic [CA_W-1:0] coef_addr
);

    localparam int RB = clog2_min1(IMG_H);
    localparam int CB = clog2_min1(IMG_W);

    logic [RB-1:0] row_sum;
    logic [CB-1:0] col_sum;

    assign row_sum = RB'(win_row) + RB'(tap_row);
    assign col_sum = CB'(win_col) + CB'(tap_col);

    generate
        if (is_pow2(IMG_W) && (RB + CB == IA_W)) begin : g_concat
            assign img_addr = {row_sum, col_sum};
        end else begin : g_mult
            assign img_addr = IA_W'(int'(row_sum) * IMG_W + int'(col_sum));
        end
    endgenerate

    assign coef_addr = CA_W'(int'(tap_row) * KSIZE + int'(tap_col));

endmodule

// File: rtl/conv_ctrl_fsm.sv
module conv_ctrl_fsm
    import conv_win_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     mac_done,
    input  logic     tap_last,
    input  logic     win_last,
    output cnt_cmd_t tap_cmd,
    output cnt_cmd_t win_cmd,
    output logic     launch,
    output logic     rd_valid,
    output logic     res_we,
    output logic     done
);

    ctrl_state_e state;
    ctrl_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_INIT, ST_FINISH: if (start) nxt = ST_ISSUE;
            ST_ISSUE:           if (tap_last) nxt = ST_ALIGN_A;
            ST_ALIGN_A:         nxt = ST_ALIGN_B;
            ST_ALIGN_B:         nxt = ST_HALT;
            ST_HALT:            nxt = ST_WAIT;
            ST_WAIT:            if (mac_done) nxt = win_last ? ST_FINISH : ST_ISSUE;
            default:            nxt = ST_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_INIT;
        else     state <= nxt;
    end

    assign launch   = ((state == ST_INIT) || (state == ST_FINISH)) && start;
    assign rd_valid = (state == ST_ISSUE);
    assign res_we   = (state == ST_WAIT) && mac_done;
    assign done     = (state == ST_FINISH);

    assign tap_cmd.clear = launch;
    assign tap_cmd.step  = rd_valid;
    assign win_cmd.clear = launch;
    assign win_cmd.step  = res_we;

endmodule

// File: rtl/conv_window_ctrl.sv
module conv_window_ctrl
    import conv_win_pkg::*;
#(
    parameter int IMG_H = 8,
    parameter int IMG_W = 8,
    parameter int KSIZE = 3,
    localparam int N_OUT = (IMG_H - KSIZE + 1) * (IMG_W - KSIZE + 1),
    localparam int IA_W  = clog2_min1(IMG_H * IMG_W),
    localparam int CA_W  = clog2_min1(KSIZE * KSIZE),
    localparam int OA_W  = clog2_min1(N_OUT + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            mac_done,
    output logic            rd_valid,
    output logic [IA_W-1:0] img_addr,
    output logic [CA_W-1:0] coef_addr,
    output logic            res_we,
    output logic [OA_W-1:0] res_addr,
    output logic            done
);

    localparam int OUT_ROWS = IMG_H - KSIZE + 1;
    localparam int OUT_COLS = IMG_W - KSIZE + 1;
    localparam int WRW = clog2_min1(OUT_ROWS);
    localparam int WCW = clog2_min1(OUT_COLS);
    localparam int TW  = clog2_min1(KSIZE);

    cnt_cmd_t       tap_cmd;
    cnt_cmd_t       win_cmd;
    logic           launch;
    logic           tap_last;
    logic           win_last;
    logic [TW-1:0]  tap_col;
    logic [TW-1:0]  tap_row;
    logic [WCW-1:0] win_col;
    logic [WRW-1:0] win_row;
    logic [OA_W-1:0] out_cnt;

    conv_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mac_done (mac_done),
        .tap_last (tap_last),
        .win_last (win_last),
        .tap_cmd  (tap_cmd),
        .win_cmd  (win_cmd),
        .launch   (launch),
        .rd_valid (rd_valid),
        .res_we   (res_we),
        .done     (done)
    );

    conv_grid_counter #(.COLS(KSIZE), .ROWS(KSIZE)) u_taps (
        .clk  (clk),
        .rst  (rst),
        .cmd  (tap_cmd),
        .col  (tap_col),
        .row  (tap_row),
        .last (tap_last)
    );

    conv_grid_counter #(.COLS(OUT_COLS), .ROWS(OUT_ROWS)) u_wins (
        .clk  (clk),
        .rst  (rst),
        .cmd  (win_cmd),
        .col  (win_col),
        .row  (win_row),
        .last (win_last)
    );

    conv_addr_gen #(.IMG_H(IMG_H), .IMG_W(IMG_W), .KSIZE(KSIZE)) u_addr (
        .win_row   (win_row),
        .win_col   (win_col),
        .tap_row   (tap_row),
        .tap_col   (tap_col),
        .img_addr  (img_addr),
        .coef_addr (coef_addr)
    );

    always_ff @(posedge clk) begin
        if (rst || launch) out_cnt <= '0;
        else if (res_we)   out_cnt <= out_cnt + 1'b1;
    end

    assign res_addr = out_cnt;

endmodule

// File: rtl/conv_window_ctrl_chk.sv
module conv_window_ctrl_chk
    import conv_win_pkg::*;
#(
    parameter int IMG_H = 8,
    parameter int IMG_W = 8,
    parameter int KSIZE = 3,
    localparam int N_OUT = (IMG_H - KSIZE + 1) * (IMG_W - KSIZE + 1),
    localparam int IA_W  = clog2_min1(IMG_H * IMG_W),
    localparam int CA_W  = clog2_min1(KSIZE * KSIZE),
    localparam int OA_W  = clog2_min1(N_OUT + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            rd_valid,
    input logic [IA_W-1:0] img_addr,
    input logic [CA_W-1:0] coef_addr,
    input logic            res_we,
    input logic [OA_W-1:0] res_addr,
    input logic            done
);

    // R3: every strobed address lies inside its memory
    p_addr_range_r3: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (int'(coef_addr) < KSIZE * KSIZE) && (int'(img_addr) < IMG_H * IMG_W));

    // R3: a burst opens on the first coefficient
    p_burst_first_tap_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> (coef_addr == '0));

    // R4: three quiet cycles follow each burst
    p_gap_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_valid) |-> !res_we ##1 (!rd_valid && !res_we) ##1 (!rd_valid && !res_we));

    // R6: a write never coincides with a strobe or the finished flag
    p_write_excl_r6: assert property (@(posedge clk) disable iff (rst)
        res_we |-> (!rd_valid && !done));

    // R6: one write per handshake
    p_single_write_r6: assert property (@(posedge clk) disable iff (rst)
        res_we |=> !res_we);

    // R6: result address steps by one after each write
    p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
        res_we |=> (res_addr == $past(res_addr) + 1'b1));

    // R7: the finished flag implies a full set of results
    p_full_count_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (res_addr == OA_W'(N_OUT)));

    // R8: finished flag held until a start
    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R8: finishing is preceded directly by the last write
    p_done_after_write_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(res_we));

endmodule

bind conv_window_ctrl conv_window_ctrl_chk #(
    .IMG_H(IMG_H), .IMG_W(IMG_W), .KSIZE(KSIZE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rd_valid  (rd_valid),
    .img_addr  (img_addr),
    .coef_addr (coef_addr),
    .res_we    (res_we),
    .res_addr  (res_addr),
    .done      (done)
);

// File: tb/conv_window_ctrl_bench.sv
module conv_window_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int H = 8;
    localparam int W = 8;
    localparam int K = 3;
    localparam int OR_N = H - K + 1;
    localparam int OC_N = W - K + 1;
    localparam int N_OUT = OR_N * OC_N;
    localparam int IA_W = $clog2(H * W);
    localparam int CA_W = $clog2(K * K);
    localparam int OA_W = $clog2(N_OUT + 1);
    localparam int WATCHDOG = 50000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic mac_done = 1'b0;
    logic rd_valid;
    logic [IA_W-1:0] img_addr;
    logic [CA_W-1:0] coef_addr;
    logic res_we;
    logic [OA_W-1:0] res_addr;
    logic done;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int writes = 0;
    int run_mode = 0;
    logic [31:0] lfsr = 32'h1ACE_5EED;

    // reference model state: 0 idle, 1 issue, 2 gap, 3 wait, 4 finished
    int m_mode = 0;
    int m_t = 0;
    int m_g = 0;
    int m_i = 0;
    int m_j = 0;
    int m_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    conv_window_ctrl #(.IMG_H(H), .IMG_W(W), .KSIZE(K)) u_conv_window_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mac_done  (mac_done),
        .rd_valid  (rd_valid),
        .img_addr  (img_addr),
        .coef_addr (coef_addr),
        .res_we    (res_we),
        .res_addr  (res_addr),
        .done      (done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string tag_for(input int mode, input logic st, input logic md);
        if (st && (mode != 0) && (mode != 4)) return "R10";
        if (md && (mode != 3)) return "R9";
        case (mode)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic compare(input logic st, input logic md);
        string tg;
        int e_img;
        bit e_we;
        tg = tag_for(m_mode, st, md);
        e_img = (m_i + m_t / K) * W + m_j + m_t % K;
        e_we = (m_mode == 3) && md;
        chk(rd_valid === (m_mode == 1), tg, "rd_valid", int'(rd_valid), int'(m_mode == 1));
        if (m_mode == 1) begin
            chk(int'(img_addr) == e_img, tg, "img_addr", int'(img_addr), e_img);
            chk(int'(coef_addr) == m_t, tg, "coef_addr", int'(coef_addr), m_t);
        end
        chk(res_we === e_we, e_we ? "R6" : tg, "res_we", int'(res_we), int'(e_we));
        chk(int'(res_addr) == m_cnt, "R6", "res_addr", int'(res_addr), m_cnt);
        chk(done === (m_mode == 4), tg, "done", int'(done), int'(m_mode == 4));
        if (res_we === 1'b1) writes++;
    endtask

    task automatic advance(input logic st, input logic md);
        case (m_mode)
            0, 4: if (st) begin
                m_mode = 1; m_t = 0; m_i = 0; m_j = 0; m_cnt = 0;
            end
            1: if (m_t == K * K - 1) begin m_mode = 2; m_g = 0; end
               else m_t++;
            2: if (m_g == 2) m_mode = 3; else m_g++;
            3: if (md) begin
                m_cnt++;
                if (m_i == OR_N - 1 && m_j == OC_N - 1) m_mode = 4;
                else begin
                    m_mode = 1; m_t = 0;
                    if (m_j == OC_N - 1) begin m_j = 0; m_i++; end
                    else m_j++;
                end
            end
            default: ;
        endcase
    endtask

    // called just after a falling edge
    task automatic tick(input logic st, input logic md);
        start = st;
        mac_done = md;
        #1;
        compare(st, md);
        @(posedge clk);
        advance(st, md);
        @(negedge clk);
    endtask

    function automatic logic pick_md();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        case (run_mode)
            0: return 1'b1;
            1: return lfsr[0] & lfsr[1];
            default: return lfsr[2];
        endcase
    endfunction

    function automatic logic pick_start();
        return (run_mode == 2) && (lfsr[5:3] == 3'd0);
    endfunction

    task automatic run_pass(input int mode);
        run_mode = mode;
        writes = 0;
        tick(1'b1, pick_md());
        // R2: first tap presented in the cycle after start
        chk(rd_valid === 1'b1 && img_addr == '0 && coef_addr == '0, "R2",
            "first tap after start", int'(img_addr), 0);
        while (m_mode != 4) tick(pick_start(), pick_md());
        chk(writes == N_OUT, "R7", "results per pass", writes, N_OUT);
        repeat (4) tick(1'b0, pick_md());
        chk(done === 1'b1 && int'(res_addr) == N_OUT, "R8", "done held",
            int'(res_addr), N_OUT);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog: actual %0d expected %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(rd_valid === 1'b0 && res_we === 1'b0 && done === 1'b0 && res_addr == '0,
            "R1", "reset outputs", int'(res_addr), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_valid === 1'b0 && res_we === 1'b0 && done === 1'b0, "R1",
            "after reset", int'(done), 0);
        repeat (3) tick(1'b0, 1'b1);   // R9: mac_done ignored while idle
        run_pass(0);
        run_pass(1);
        run_pass(2);
        run_pass(1);                   // R8: relaunch from finished state
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule